// File: doc/BRIEF.md
# Store Merge Buffer with Byte-Level Load Forwarding

This block sits between the processor's store port and a data cache. Every store the processor issues is accepted into a small first-in first-out queue of word-sized entries. The processor keeps running, and a store that misses in the cache starts a block fill on its way in. Each entry holds a word address, four data bytes and one valid flag per byte. The entry at the head of the queue is offered to the cache, and it is written there once the cache signals that the entry's block is present. Only a full queue stalls the processor.

Loads look up the buffer in the same cycle that they read the cache. For every byte lane, the returned word takes the youngest buffered byte for that word address if one exists, and the cache byte otherwise. Two flags report whether any requested byte came from the buffer and whether the buffer alone supplied all of them. A store to the same word as the newest entry merges into that entry, so runs of narrow stores to one word use a single slot.

Occupancy is tracked by a three-state machine: `OCC_EMPTY`, `OCC_PARTIAL` and `OCC_FULL`. The first store moves it from `OCC_EMPTY` to `OCC_PARTIAL` (or straight to `OCC_FULL` when the depth is one). Filling the last slot moves it from `OCC_PARTIAL` to `OCC_FULL`. A drain while full moves it from `OCC_FULL` back to `OCC_PARTIAL`, and the drain of the last entry moves it from `OCC_PARTIAL` to `OCC_EMPTY`. A cycle with a store and a drain together, or with a merge only, keeps the current state.

Top module: `store_merge_buffer`

## Requirements
- R1: After reset, `st_ready` is 1, `drn_valid` is 0, and a load to any address reports `ld_buf_hit` = 0 and returns the cache word unchanged.
- R2: When `st_ready` is 1, a store with `st_valid` = 1 whose word address differs from the newest entry takes a new entry at the tail of the queue.
- R3: `fill_req` is 1 in exactly the cycles where a store is accepted while `st_cache_hit` = 0, and `fill_addr` then equals `st_addr`. A stalled store or a cache-hitting store raises no fill.
- R4: `st_ready` is 0 exactly when all DEPTH entries are occupied and the store address does not match the newest entry. A store presented while `st_ready` is 0 changes no entry.
- R5: A store to the same word address as the newest entry is merged into it: the lanes enabled in `st_be` (bit b covers data bits 8b+7..8b) are overwritten, its byte-valid flags become the OR of both, and the occupancy does not grow. This holds even when the queue is full.
- R6: `drn_valid` is 1 whenever the queue is non-empty, and `drn_addr`/`drn_data`/`drn_be` show the oldest entry. The entry is removed in a cycle with `drn_blk_ready` = 1, and entries leave in arrival order.
- R7: For each byte lane, `ld_data` carries the buffered byte when some entry with word address `ld_addr` has that lane valid, and the `ld_cache_data` byte otherwise.
- R8: When several entries for the same word hold a lane, the youngest entry supplies that lane.
- R9: `ld_buf_hit` is 1 when at least one lane enabled in `ld_be` comes from the buffer. `ld_full` is 1 only when `ld_be` is non-zero and every lane it enables comes from the buffer.
- R10: When a single entry remains and is drained in the same cycle as a store to its word, the store takes a new entry instead of merging into the departing one.
- R11: In an entry's data, lanes whose byte-valid flag is 0 read as zero on `drn_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request |
| st_addr | input | ADDR_W | Store word address |
| st_data | input | DATA_W | Store data |
| st_be | input | DATA_W/8 | Store byte enables |
| st_cache_hit | input | 1 | Cache lookup of the store address hit |
| st_ready | output | 1 | Store accepted this cycle if valid; 0 means stall |
| fill_req | output | 1 | Start a block fill for the accepted store |
| fill_addr | output | ADDR_W | Word address for the fill |
| ld_addr | input | ADDR_W | Load word address |
| ld_be | input | DATA_W/8 | Load byte lanes requested |
| ld_cache_data | input | DATA_W | Word read from the cache for the load |
| ld_data | output | DATA_W | Merged load word |
| ld_buf_hit | output | 1 | Some requested lane came from the buffer |
| ld_full | output | 1 | All requested lanes came from the buffer |
| drn_valid | output | 1 | Oldest entry is available to drain |
| drn_addr | output | ADDR_W | Word address of the oldest entry |
| drn_data | output | DATA_W | Data of the oldest entry |
| drn_be | output | DATA_W/8 | Byte-valid flags of the oldest entry |
| drn_blk_ready | input | 1 | The oldest entry's block is present and the cache takes the write |

## Verification
The bench builds the block with DEPTH = 4, a 4-bit word address and 32-bit data, so there are only sixteen word addresses. After every few operations it can sweep every one of them with full-word, single-lane and mixed lane masks. Store addresses are drawn from a narrow range, so the queue reaches full, merges into the newest entry happen often, and several entries for one word coexist, which exercises the youngest-wins rule on each lane. Directed sequences cover a merge while full, a stalled store, and a store that meets the drain of the last entry in the same cycle.

// File: rtl/smb_pkg.sv
package smb_pkg;
    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_e;
endpackage

// File: rtl/smb_store_array.sv
module smb_store_array #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push,
    input  logic                          merge,
    input  logic                          pop,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic [DATA_W/8-1:0]           wr_be,
    output logic [ADDR_W-1:0]             ent_addr [DEPTH],
    output logic [DATA_W-1:0]             ent_data [DEPTH],
    output logic [DATA_W/8-1:0]           ent_be   [DEPTH],
    output logic [((DEPTH>1)?$clog2(DEPTH):1)-1:0] head_ptr,
    output logic [ADDR_W-1:0]             newest_addr
);
    localparam int NB    = DATA_W / 8;
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [PTR_W-1:0] tail_ptr;
    logic [PTR_W-1:0] newest_ptr;

    assign newest_ptr  = (tail_ptr == '0) ? LAST : tail_ptr - 1'b1;
    assign newest_addr = ent_addr[newest_ptr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_ptr <= '0;
            tail_ptr <= '0;
            for (int e = 0; e < DEPTH; e++) begin
                ent_addr[e] <= '0;
                ent_data[e] <= '0;
                ent_be[e]   <= '0;
            end
        end else begin
            if (push) begin
                ent_addr[tail_ptr] <= wr_addr;
                ent_be[tail_ptr]   <= wr_be;
                for (int b = 0; b < NB; b++)
                    ent_data[tail_ptr][8*b +: 8] <= wr_be[b] ? wr_data[8*b +: 8] : 8'h00;
                tail_ptr <= (tail_ptr == LAST) ? '0 : tail_ptr + 1'b1;
            end else if (merge) begin
                ent_be[newest_ptr] <= ent_be[newest_ptr] | wr_be;
                for (int b = 0; b < NB; b++)
                    if (wr_be[b]) ent_data[newest_ptr][8*b +: 8] <= wr_data[8*b +: 8];
            end
            if (pop)
                head_ptr <= (head_ptr == LAST) ? '0 : head_ptr + 1'b1;
        end
    end

    // A merge never allocates a slot (R5)
    assert_merge_keeps_tail_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (merge && !push) |=> $stable(tail_ptr));

    // A drain advances the head by exactly one slot, keeping arrival order (R6)
    assert_head_steps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> (head_ptr != $past(head_ptr)));

    // Without a drain the head stays put (R6)
    assert_head_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !pop |=> $stable(head_ptr));
endmodule

// File: rtl/smb_lookup.sv
module smb_lookup #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32
) (
    input  logic [ADDR_W-1:0]             ent_addr [DEPTH],
    input  logic [DATA_W-1:0]             ent_data [DEPTH],
    input  logic [DATA_W/8-1:0]           ent_be   [DEPTH],
    input  logic [((DEPTH>1)?$clog2(DEPTH):1)-1:0] head_ptr,
    input  logic [$clog2(DEPTH+1)-1:0]    occupancy,
    input  logic [ADDR_W-1:0]             ld_addr,
    input  logic [DATA_W/8-1:0]           ld_be,
    input  logic [DATA_W-1:0]             ld_cache_data,
    output logic [DATA_W-1:0]             ld_data,
    output logic                          ld_buf_hit,
    output logic                          ld_full
);
    localparam int NB    = DATA_W / 8;
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [NB-1:0] lane_hit;

    // Walk from oldest to youngest so later entries override earlier ones.
    always_comb begin
        ld_data  = ld_cache_data;
        lane_hit = '0;
        for (int k = 0; k < DEPTH; k++) begin
            int slot;
            slot = int'(head_ptr) + k;
            if (slot >= DEPTH) slot = slot - DEPTH;
            if ((k < int'(occupancy)) && (ent_addr[PTR_W'(slot)] == ld_addr)) begin
                for (int b = 0; b < NB; b++) begin
                    if (ent_be[PTR_W'(slot)][b]) begin
                        ld_data[8*b +: 8] = ent_data[PTR_W'(slot)][8*b +: 8];
                        lane_hit[b]       = 1'b1;
                    end
                end
            end
        end
    end

    assign ld_buf_hit = |(ld_be & lane_hit);
    assign ld_full    = (ld_be != '0) && ((ld_be & ~lane_hit) == '0);
endmodule

// File: rtl/store_merge_buffer.sv
module store_merge_buffer
    import smb_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 st_valid,
    input  logic [ADDR_W-1:0]    st_addr,
    input  logic [DATA_W-1:0]    st_data,
    input  logic [DATA_W/8-1:0]  st_be,
    input  logic                 st_cache_hit,
    output logic                 st_ready,
    output logic                 fill_req,
    output logic [ADDR_W-1:0]    fill_addr,
    input  logic [ADDR_W-1:0]    ld_addr,
    input  logic [DATA_W/8-1:0]  ld_be,
    input  logic [DATA_W-1:0]    ld_cache_data,
    output logic [DATA_W-1:0]    ld_data,
    output logic                 ld_buf_hit,
    output logic                 ld_full,
    output logic                 drn_valid,
    output logic [ADDR_W-1:0]    drn_addr,
    output logic [DATA_W-1:0]    drn_data,
    output logic [DATA_W/8-1:0]  drn_be,
    input  logic                 drn_blk_ready
);
    localparam int NB    = DATA_W / 8;
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

    occ_e             state, state_nxt;
    logic [CNT_W-1:0] count, count_nxt;

    logic [ADDR_W-1:0] ent_addr [DEPTH];
    logic [DATA_W-1:0] ent_data [DEPTH];
    logic [NB-1:0]     ent_be   [DEPTH];
    logic [PTR_W-1:0]  head_ptr;
    logic [ADDR_W-1:0] newest_addr;

    logic merge_ok, do_push, do_merge, do_pop;

    // Merging is refused when the only entry is leaving this cycle (R10).
    assign do_pop   = drn_valid && drn_blk_ready;
    assign merge_ok = (state != OCC_EMPTY) && (newest_addr == st_addr) &&
                      !((count == ONE_CNT) && do_pop);
    assign do_merge = st_valid && merge_ok;
    assign do_push  = st_valid && st_ready && !merge_ok;

    always_comb begin
        count_nxt = count;
        if (do_push && !do_pop)      count_nxt = count + 1'b1;
        else if (!do_push && do_pop) count_nxt = count - 1'b1;
    end

    // Next-state decision
    always_comb begin
        state_nxt = state;
        unique case (state)
            OCC_EMPTY: begin
                if (count_nxt == FULL_CNT)  state_nxt = OCC_FULL;     // first store, depth one
                else if (count_nxt != '0)   state_nxt = OCC_PARTIAL;  // first store
            end
            OCC_PARTIAL: begin
                if (count_nxt == '0)            state_nxt = OCC_EMPTY; // last drain
                else if (count_nxt == FULL_CNT) state_nxt = OCC_FULL;  // fill-up
            end
            OCC_FULL: begin
                if (count_nxt == '0)            state_nxt = OCC_EMPTY;   // depth one drain
                else if (count_nxt != FULL_CNT) state_nxt = OCC_PARTIAL; // relief
            end
            default: state_nxt = OCC_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= OCC_EMPTY;
            count <= '0;
        end else begin
            state <= state_nxt;
            count <= count_nxt;
        end
    end

    // Outputs
    always_comb begin
        drn_valid = (state != OCC_EMPTY);
        st_ready  = (state != OCC_FULL) || merge_ok;
        fill_req  = st_valid && st_ready && !st_cache_hit;
        fill_addr = st_addr;
        drn_addr  = ent_addr[head_ptr];
        drn_data  = ent_data[head_ptr];
        drn_be    = ent_be[head_ptr];
    end

    smb_store_array #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk         (clk),
        .rst_n       (rst_n),
        .push        (do_push),
        .merge       (do_merge),
        .pop         (do_pop),
        .wr_addr     (st_addr),
        .wr_data     (st_data),
        .wr_be       (st_be),
        .ent_addr    (ent_addr),
        .ent_data    (ent_data),
        .ent_be      (ent_be),
        .head_ptr    (head_ptr),
        .newest_addr (newest_addr)
    );

    smb_lookup #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_lookup (
        .ent_addr      (ent_addr),
        .ent_data      (ent_data),
        .ent_be        (ent_be),
        .head_ptr      (head_ptr),
        .occupancy     (count),
        .ld_addr       (ld_addr),
        .ld_be         (ld_be),
        .ld_cache_data (ld_cache_data),
        .ld_data       (ld_data),
        .ld_buf_hit    (ld_buf_hit),
        .ld_full       (ld_full)
    );

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

    assert_stall_only_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !st_ready |-> (state == OCC_FULL));

    assert_fill_leaves_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |=> (state != OCC_EMPTY));

    assert_drain_has_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        drn_valid |-> (count != '0));

    assert_empty_matches_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == OCC_EMPTY) |-> (count == '0));

    assert_full_implies_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ld_full |-> ld_buf_hit);
endmodule

// File: tb/store_merge_buffer_tb.sv
module store_merge_buffer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 4;
    localparam int AW    = 4;
    localparam int DW    = 32;
    localparam int NB    = DW / 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          st_valid, st_cache_hit, st_ready, fill_req;
    logic [AW-1:0] st_addr, fill_addr, ld_addr, drn_addr;
    logic [DW-1:0] st_data, ld_cache_data, ld_data, drn_data;
    logic [NB-1:0] st_be, ld_be, drn_be;
    logic          ld_buf_hit, ld_full, drn_valid, drn_blk_ready;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;
    logic [31:0] rng = 32'h1d2c_3b4a;

    // Bench model of the queue, index 0 is the oldest entry.
    int          m_cnt = 0;
    logic [AW-1:0] m_addr [DEPTH];
    logic [DW-1:0] m_data [DEPTH];
    logic [NB-1:0] m_be   [DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    store_merge_buffer #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
        .st_cache_hit(st_cache_hit), .st_ready(st_ready),
        .fill_req(fill_req), .fill_addr(fill_addr),
        .ld_addr(ld_addr), .ld_be(ld_be), .ld_cache_data(ld_cache_data),
        .ld_data(ld_data), .ld_buf_hit(ld_buf_hit), .ld_full(ld_full),
        .drn_valid(drn_valid), .drn_addr(drn_addr), .drn_data(drn_data), .drn_be(drn_be),
        .drn_blk_ready(drn_blk_ready)
    );

    function automatic logic [31:0] next_rng(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // One clock cycle with an optional store and an optional drain grant.
    task automatic step(input bit sv, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [NB-1:0] be, input bit hit, input bit pop);
        bit pop_eff, mrg, rdy, fil;
        logic [DW-1:0] masked;
        @(negedge clk);
        st_valid = sv; st_addr = a; st_data = d; st_be = be; st_cache_hit = hit;
        drn_blk_ready = pop;
        #1;
        pop_eff = pop && (m_cnt > 0);
        mrg = (m_cnt > 0) && (m_addr[m_cnt-1] == a) && !((m_cnt == 1) && pop_eff);
        rdy = (m_cnt < DEPTH) || mrg;
        fil = sv && rdy && !hit;
        check(st_ready == rdy, "R4 st_ready", {31'd0, st_ready}, {31'd0, rdy});
        check(fill_req == fil, "R3 fill_req", {31'd0, fill_req}, {31'd0, fil});
        if (fil) check(fill_addr == a, "R3 fill_addr", {28'd0, fill_addr}, {28'd0, a});
        check(drn_valid == (m_cnt > 0), "R6 drn_valid", {31'd0, drn_valid}, {31'd0, m_cnt > 0});
        if (m_cnt > 0) begin
            check(drn_addr == m_addr[0], "R6 drn_addr", {28'd0, drn_addr}, {28'd0, m_addr[0]});
            check(drn_data == m_data[0], "R11 drn_data", drn_data, m_data[0]);
            check(drn_be == m_be[0], "R5 drn_be", {28'd0, drn_be}, {28'd0, m_be[0]});
        end
        @(posedge clk);
        masked = '0;
        for (int b = 0; b < NB; b++) if (be[b]) masked[8*b +: 8] = d[8*b +: 8];
        if (sv && rdy && mrg) begin
            for (int b = 0; b < NB; b++)
                if (be[b]) m_data[m_cnt-1][8*b +: 8] = d[8*b +: 8];
            m_be[m_cnt-1] = m_be[m_cnt-1] | be;
        end
        if (pop_eff) begin
            for (int i = 0; i < DEPTH-1; i++) begin
                m_addr[i] = m_addr[i+1]; m_data[i] = m_data[i+1]; m_be[i] = m_be[i+1];
            end
            m_cnt--;
        end
        if (sv && rdy && !mrg) begin
            m_addr[m_cnt] = a; m_data[m_cnt] = masked; m_be[m_cnt] = be;
            m_cnt++;
        end
        #1;
        st_valid = 1'b0; drn_blk_ready = 1'b0;
    endtask

    // Load sweep over every word address with three lane masks.
    task automatic sweep();
        for (int a = 0; a < 16; a++) begin
            @(negedge clk);
            for (int j = 0; j < 3; j++) begin
                logic [NB-1:0] lb;
                logic [DW-1:0] cd, exp_d;
                logic [NB-1:0] found;
                bit e_any, e_all;
                rng = next_rng(rng);
                lb = (j == 0) ? 4'hF : (j == 1) ? (4'b0001 << (a % 4)) : rng[3:0];
                cd = {4{a[3:0], 4'hA}} ^ rng;
                ld_addr = a[AW-1:0]; ld_be = lb; ld_cache_data = cd;
                #1;
                exp_d = cd; found = '0;
                for (int i = 0; i < m_cnt; i++)
                    if (m_addr[i] == a[AW-1:0])
                        for (int b = 0; b < NB; b++)
                            if (m_be[i][b]) begin
                                exp_d[8*b +: 8] = m_data[i][8*b +: 8];
                                found[b] = 1'b1;
                            end
                e_any = |(lb & found);
                e_all = (lb != 0) && ((lb & ~found) == 0);
                check(ld_data == exp_d, "R7/R8 ld_data", ld_data, exp_d);
                check(ld_buf_hit == e_any, "R9 ld_buf_hit", {31'd0, ld_buf_hit}, {31'd0, e_any});
                check(ld_full == e_all, "R9 ld_full", {31'd0, ld_full}, {31'd0, e_all});
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; st_valid = 1'b0; st_addr = '0; st_data = '0; st_be = '0;
        st_cache_hit = 1'b0; drn_blk_ready = 1'b0;
        ld_addr = '0; ld_be = 4'hF; ld_cache_data = 32'hCAFE_F00D;
        for (int i = 0; i < DEPTH; i++) begin m_addr[i] = '0; m_data[i] = '0; m_be[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(st_ready == 1'b1, "R1 st_ready", {31'd0, st_ready}, 32'd1);
        check(drn_valid == 1'b0, "R1 drn_valid", {31'd0, drn_valid}, 32'd0);
        check(ld_buf_hit == 1'b0, "R1 ld_buf_hit", {31'd0, ld_buf_hit}, 32'd0);
        check(ld_data == 32'hCAFE_F00D, "R1 ld_data", ld_data, 32'hCAFE_F00D);
        rst_n = 1'b1;
        sweep();

        // R2/R5: new entry then merges into the newest word
        step(1, 4'd1, 32'h1111_1111, 4'b0001, 0, 0);
        step(1, 4'd1, 32'h2222_2222, 4'b0010, 1, 0);
        step(1, 4'd2, 32'h3333_3333, 4'b1100, 0, 0);
        step(1, 4'd1, 32'h4444_4444, 4'b0011, 0, 0);   // R8: younger entry for word 1
        sweep();
        step(1, 4'd3, 32'h5555_5555, 4'b1111, 1, 0);   // fills the queue
        step(1, 4'd5, 32'h6666_6666, 4'b1111, 0, 0);   // R4: stalled, no fill
        step(1, 4'd3, 32'h7777_7777, 4'b1000, 0, 0);   // R5: merge while full
        sweep();
        // R6: drain in order down to one entry
        step(0, 4'd0, 32'h0, 4'b0000, 0, 1);
        step(0, 4'd0, 32'h0, 4'b0000, 0, 1);
        step(0, 4'd0, 32'h0, 4'b0000, 0, 1);
        // R10: store to the departing single entry takes a new slot
        step(1, 4'd3, 32'h8888_8888, 4'b0100, 0, 1);
        sweep();
        step(0, 4'd0, 32'h0, 4'b0000, 0, 1);
        sweep();

        // Pseudo-random mix over a narrow address range
        for (int n = 0; n < 160; n++) begin
            logic [31:0] r, d;
            logic [NB-1:0] be;
            rng = next_rng(rng); r = rng;
            rng = next_rng(rng); d = rng;
            be = (r[7:4] == 0) ? 4'b0001 : r[7:4];
            step(r[9] | r[10], {1'b0, r[2:0] % 3'd5}, d, be, r[8], r[11] & r[12]);
            if (n % 5 == 4) sweep();
        end
        for (int n = 0; n < DEPTH + 1; n++) step(0, 4'd0, 32'h0, 4'b0000, 0, 1);
        sweep();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule